// File: doc/BRIEF.md
# Multi-Cycle Shared-Resource Processor Datapath

This block is the datapath of a 32-bit load/store processor. Each instruction is spread over several short clock cycles. One memory port serves both instruction fetch and data access, and one ALU is reused in every cycle. Between cycles, values are held in an instruction register, a memory data register, two operand registers and an ALU result register. A register file with two read ports and one write port holds the architectural state.

The datapath has no sequencing of its own. An external controller drives its write enables and multiplexer selects once per cycle. The datapath returns the opcode, the function code and the ALU zero flag to that controller. The memory sits outside the block. It is word-addressed through address bits [9:2] upward, reads combinationally and writes on the clock edge under a strobe from the controller.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous reset clears the PC, the instruction register, the temporary registers and every general register. After reset, opcode and funct read 0.
- R2: `mem_addr` carries the PC when `addr_sel`=0 and the ALU result register when `addr_sel`=1. `mem_wdata` carries operand register B.
- R3: The instruction register loads `mem_rdata` only on a cycle with `ir_we`=1. `opcode` is IR[31:26] and `funct` is IR[5:0].
- R4: The write register number is IR[20:16] when `dst_sel`=0 and IR[15:11] when `dst_sel`=1. A write happens only when `reg_we`=1. Register 0 always reads zero and ignores writes.
- R5: ALU input A is the PC when `a_sel`=0 and operand register A (the rs value) when `a_sel`=1. The `b_sel` code picks input B: 00 gives register B, 01 gives the constant 4, 10 gives the sign-extended IR[15:0], and 11 gives that value shifted left by 2.
- R6: The `alu_ctl` code sets the operation: 00 is add, 01 is subtract, and 10 decodes funct. The funct codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A signed set-less-than. `zero` is 1 exactly when the live ALU result is all zeros.
- R7: The `pc_src` code picks the next PC: 00 is the live ALU result, 01 is the ALU result register, and 10 is the jump target. The jump target is the current PC[31:28], followed by IR[25:0], followed by two zero bits.
- R8: The PC is written when `pc_we`=1, or when `pc_we_cond`=1 and `zero`=1. Otherwise the PC holds.
- R9: Operand registers A and B, the ALU result register and the memory data register capture new values on every clock edge outside reset. A value produced in one cycle is therefore available in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 32 | Read data from the shared memory |
| ir_we | input | 1 | Instruction register write enable |
| pc_we | input | 1 | Unconditional PC write |
| pc_we_cond | input | 1 | PC write qualified by zero |
| addr_sel | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| dst_sel | input | 1 | Write register select: 0 IR[20:16], 1 IR[15:11] |
| mem_to_reg | input | 1 | Write data select: 0 ALU result register, 1 memory data register |
| reg_we | input | 1 | Register file write enable |
| a_sel | input | 1 | ALU input A select |
| b_sel | input | 2 | ALU input B select |
| alu_ctl | input | 2 | ALU operation control |
| pc_src | input | 2 | Next PC source |
| mem_addr | output | 32 | Shared memory byte address |
| mem_wdata | output | 32 | Store data (operand register B) |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | Live ALU result is zero |

## Verification
The bench builds the block with its default of 32 registers. This makes register 31 reachable through the 5-bit fields and lets a write to register 0 be shown to have no effect. The bench itself plays the role of the controller. It steps each instruction class through its cycle sequence, and it reads register contents back by storing them to memory. It covers branches taken and not taken, a backward branch, a jump, a negative load offset, signed set-less-than, and a reset in the middle of a run.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int NREGS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] mem_rdata,
  input  logic        ir_we,
  input  logic        pc_we,
  input  logic        pc_we_cond,
  input  logic        addr_sel,
  input  logic        dst_sel,
  input  logic        mem_to_reg,
  input  logic        reg_we,
  input  logic        a_sel,
  input  logic [1:0]  b_sel,
  input  logic [1:0]  alu_ctl,
  input  logic [1:0]  pc_src,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        zero
);
  localparam int RA = $clog2(NREGS);

  logic [31:0] pc, ir, mdr, opa_q, opb_q, aluout;
  logic [31:0] rf [NREGS];

  logic [RA-1:0] rs_i, rt_i, rd_i, wr_i;
  logic [31:0]   sx, op_a, op_b, alu_y, wdata, pc_next;
  logic [3:0]    op_sel;
  logic          pc_load;

  assign rs_i = ir[21 +: RA];
  assign rt_i = ir[16 +: RA];
  assign rd_i = ir[11 +: RA];
  assign wr_i = dst_sel ? rd_i : rt_i;

  assign opcode    = ir[31:26];
  assign funct     = ir[5:0];
  assign mem_addr  = addr_sel ? aluout : pc;
  assign mem_wdata = opb_q;
  assign wdata     = mem_to_reg ? mdr : aluout;

  assign sx   = {{16{ir[15]}}, ir[15:0]};
  assign op_a = a_sel ? opa_q : pc;

  always_comb begin
    case (b_sel)
      2'b00:   op_b = opb_q;
      2'b01:   op_b = 32'd4;
      2'b10:   op_b = sx;
      default: op_b = {sx[29:0], 2'b00};
    endcase
  end

  // 0 add, 1 sub, 2 and, 3 or, 4 slt
  always_comb begin
    case (alu_ctl)
      2'b00: op_sel = 4'd0;
      2'b01: op_sel = 4'd1;
      default: begin
        case (ir[5:0])
          6'h22:   op_sel = 4'd1;
          6'h24:   op_sel = 4'd2;
          6'h25:   op_sel = 4'd3;
          6'h2A:   op_sel = 4'd4;
          default: op_sel = 4'd0;
        endcase
      end
    endcase
  end

  always_comb begin
    case (op_sel)
      4'd1:    alu_y = op_a - op_b;
      4'd2:    alu_y = op_a & op_b;
      4'd3:    alu_y = op_a | op_b;
      4'd4:    alu_y = {31'd0, $signed(op_a) < $signed(op_b)};
      default: alu_y = op_a + op_b;
    endcase
  end

  assign zero = (alu_y == 32'd0);

  always_comb begin
    case (pc_src)
      2'b00:   pc_next = alu_y;
      2'b01:   pc_next = aluout;
      default: pc_next = {pc[31:28], ir[25:0], 2'b00};
    endcase
  end

  assign pc_load = pc_we | (pc_we_cond & zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      ir     <= '0;
      mdr    <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      aluout <= '0;
    end else begin
      if (ir_we)   ir <= mem_rdata;
      if (pc_load) pc <= pc_next;
      mdr    <= mem_rdata;
      opa_q  <= rf[rs_i];
      opb_q  <= rf[rt_i];
      aluout <= alu_y;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (reg_we && wr_i != '0) begin
      rf[wr_i] <= wdata;
    end
  end
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
  input logic        clk,
  input logic        rst,
  input logic        ir_we,
  input logic        pc_we,
  input logic        pc_we_cond,
  input logic [1:0]  pc_src,
  input logic        zero,
  input logic [31:0] pc,
  input logic [31:0] ir,
  input logic [31:0] aluout,
  input logic [31:0] alu_y
);
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == 32'd0 && ir == 32'd0));

  assert_ir_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !ir_we |=> $stable(ir));

  assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
    (pc_we && pc_src == 2'b01) |=> pc == $past(aluout));

  assert_pc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!pc_we && !pc_we_cond) |=> $stable(pc));

  assert_cond_skip_R8: assert property (@(posedge clk) disable iff (rst)
    (!pc_we && pc_we_cond && !zero) |=> $stable(pc));

  assert_aluout_capture_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> aluout == $past(alu_y));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk(clk), .rst(rst), .ir_we(ir_we), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
  .pc_src(pc_src), .zero(zero), .pc(pc), .ir(ir), .aluout(aluout), .alu_y(alu_y)
);

// File: tb/test_mc_datapath.sv
module test_mc_datapath;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        ir_we, pc_we, pc_we_cond, addr_sel, dst_sel, mem_to_reg, reg_we, a_sel, mwe;
  logic [1:0]  b_sel, alu_ctl, pc_src;
  logic [5:0]  opcode, funct;
  logic        zero;
  logic [31:0] mem [256];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mc_datapath i_mc_datapath (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .ir_we(ir_we), .pc_we(pc_we),
    .pc_we_cond(pc_we_cond), .addr_sel(addr_sel), .dst_sel(dst_sel),
    .mem_to_reg(mem_to_reg), .reg_we(reg_we), .a_sel(a_sel), .b_sel(b_sel),
    .alu_ctl(alu_ctl), .pc_src(pc_src), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .opcode(opcode), .funct(funct), .zero(zero)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mwe) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // {instr, kind(0 none,1 reg,2 pc), reg, req, expected}
  localparam int NV = 18;
  localparam logic [74:0] TBL [NV] = '{
    {enc_i(6'h08, 5'd0, 5'd1, 16'h0005),   2'd1, 5'd1,  4'd5, 32'h0000_0005}, // R5 imm
    {enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD),   2'd1, 5'd2,  4'd5, 32'hFFFF_FFFD}, // R5 sign ext
    {enc_r(5'd1, 5'd2, 5'd3, 6'h20),       2'd1, 5'd3,  4'd6, 32'h0000_0002}, // R6 add
    {enc_r(5'd1, 5'd2, 5'd4, 6'h22),       2'd1, 5'd4,  4'd6, 32'h0000_0008}, // R6 sub
    {enc_r(5'd1, 5'd2, 5'd5, 6'h24),       2'd1, 5'd5,  4'd6, 32'h0000_0005}, // R6 and
    {enc_r(5'd1, 5'd2, 5'd6, 6'h25),       2'd1, 5'd6,  4'd6, 32'hFFFF_FFFD}, // R6 or
    {enc_r(5'd2, 5'd1, 5'd7, 6'h2A),       2'd1, 5'd7,  4'd6, 32'h0000_0001}, // R6 slt true
    {enc_r(5'd1, 5'd2, 5'd8, 6'h2A),       2'd1, 5'd8,  4'd6, 32'h0000_0000}, // R6 slt false
    {enc_i(6'h2B, 5'd0, 5'd1, 16'h0200),   2'd0, 5'd0,  4'd2, 32'h0000_0000}, // R2 store
    {enc_i(6'h23, 5'd0, 5'd9, 16'h0200),   2'd1, 5'd9,  4'd9, 32'h0000_0005}, // R9 load via MDR
    {enc_i(6'h08, 5'd1, 5'd0, 16'h0007),   2'd1, 5'd0,  4'd4, 32'h0000_0000}, // R4 r0 ignores
    {enc_i(6'h04, 5'd1, 5'd2, 16'h000A),   2'd2, 5'd0,  4'd8, 32'h0000_0058}, // R8 not taken
    {enc_i(6'h04, 5'd1, 5'd9, 16'h0004),   2'd2, 5'd0,  4'd8, 32'h0000_006C}, // R8 taken
    {{6'h02, 26'h000_0040},                2'd2, 5'd0,  4'd7, 32'h0000_0100}, // R7 jump
    {enc_i(6'h04, 5'd0, 5'd0, 16'hFFFE),   2'd2, 5'd0,  4'd5, 32'h0000_00FC}, // R5 back branch
    {enc_i(6'h08, 5'd0, 5'd10, 16'h0210),  2'd1, 5'd10, 4'd5, 32'h0000_0210}, // R5
    {enc_i(6'h23, 5'd10, 5'd11, 16'hFFF0), 2'd1, 5'd11, 4'd2, 32'h0000_0005}, // R2 neg offset
    {enc_r(5'd1, 5'd1, 5'd31, 6'h20),      2'd1, 5'd31, 4'd4, 32'h0000_000A}  // R4 rd=31
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    {ir_we, pc_we, pc_we_cond, addr_sel, dst_sel, mem_to_reg, reg_we, a_sel, mwe} = '0;
    b_sel = 2'b00; alu_ctl = 2'b00; pc_src = 2'b00;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic ex_addr();
    clr(); a_sel = 1; b_sel = 2'b10; step();
  endtask

  task automatic run_one();
    clr(); ir_we = 1; b_sel = 2'b01; pc_we = 1; step();
    clr(); b_sel = 2'b11; step();
    case (opcode)
      6'h00: begin
        clr(); a_sel = 1; alu_ctl = 2'b10; step();
        clr(); dst_sel = 1; reg_we = 1; step();
      end
      6'h08: begin ex_addr(); clr(); reg_we = 1; step(); end
      6'h23: begin
        ex_addr();
        clr(); addr_sel = 1; step();
        clr(); mem_to_reg = 1; reg_we = 1; step();
      end
      6'h2B: begin ex_addr(); clr(); addr_sel = 1; mwe = 1; step(); end
      6'h04: begin
        clr(); a_sel = 1; alu_ctl = 2'b01; pc_src = 2'b01; pc_we_cond = 1; step();
      end
      default: begin clr(); pc_src = 2'b10; pc_we = 1; step(); end
    endcase
    clr(); #1;
  endtask

  task automatic place(input logic [31:0] instr);
    clr(); #1;
    mem[mem_addr[9:2]] = instr;
    run_one();
  endtask

  task automatic peek(input logic [4:0] r, output logic [31:0] v);
    place(enc_i(6'h2B, 5'd0, r, 16'h03F0));
    v = mem[252];
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_up();
  end

  initial begin
    logic [31:0] v, pc_keep;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    clr();
    rst = 1;
    repeat (2) @(posedge clk);
    #2 rst = 0;
    #1;
    chk("R1 pc", mem_addr, 32'd0);
    chk("R1 opcode", {26'd0, opcode}, 32'd0);
    chk("R1 funct", {26'd0, funct}, 32'd0);
    chk("R6 zero on 0+0", {31'd0, zero}, 32'd1);
    addr_sel = 1; #1;
    chk("R2 aluout addr", mem_addr, 32'd0);
    clr(); #1;

    for (int k = 0; k < NV; k++) begin
      logic [74:0] e;
      e = TBL[k];
      place(e[74:43]);
      if (e[42:41] == 2'd1) begin
        peek(e[40:36], v);
        chk($sformatf("R%0d row %0d", e[35:32], k), v, e[31:0]);
      end else if (e[42:41] == 2'd2) begin
        chk($sformatf("R%0d row %0d", e[35:32], k), mem_addr, e[31:0]);
      end
    end
    chk("R2 stored word", mem[128], 32'd5);

    // R3: IR holds without ir_we, loads with it; R8: PC holds without writes
    clr(); #1;
    pc_keep = mem_addr;
    mem[pc_keep[9:2]] = {6'h02, 26'd3};
    step();
    chk("R3 hold opcode", {26'd0, opcode}, 32'h2B);
    ir_we = 1; step(); clr(); #1;
    chk("R3 load opcode", {26'd0, opcode}, 32'h02);
    mem[pc_keep[9:2]] = enc_r(5'd1, 5'd2, 5'd3, 6'h2A);
    ir_we = 1; step(); clr(); #1;
    chk("R3 funct", {26'd0, funct}, 32'h2A);
    chk("R8 pc held", mem_addr, pc_keep);

    // R1: reset in the middle of a run
    rst = 1; step(); rst = 0; #1;
    chk("R1 mid pc", mem_addr, 32'd0);
    chk("R1 mid opcode", {26'd0, opcode}, 32'd0);
    peek(5'd1, v);
    chk("R1 regs cleared", v, 32'd0);

    finish_up();
  end
endmodule